// File: doc/BRIEF.md
# Three-Source Frame Sync Generator

This block produces the event that starts or re-aligns a frame sequencer. Three independent sources can raise that event. The first is an internal periodic source: a free-running counter that fires when it reaches a programmed terminal value. The second is an external timing input, for example a once-per-second pulse. This input can optionally be brought through a two-flop synchronizer and is then edge-detected. The third is a software strobe, raised by a single write of a one.

Each source has its own enable, and any combination of them may be on at once. Their events are merged into one registered single-cycle pulse. That pulse feeds the sequencer and also leaves the block on a sync output pin.

The terminal value is loaded one 32-bit word at a time through a small load port. Loads are only accepted while the surrounding engine is disabled. The internal period therefore cannot shift under a running frame sequence.

Top module: `tri_sync_gen`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `syncPulse` and `syncOut` are low.
- R2: When `softWrite` is high on a clock edge while `softEn` is high, `syncPulse` is high for exactly the following cycle. When `softEn` is low, `softWrite` produces no pulse.
- R3: With `intEn` high and a terminal value T, the first internal pulse appears T+1 cycles after `intEn` is raised, and pulses then repeat every T+1 cycles.
- R4: While `intEn` is low the internal counter is held at zero and gives no pulse. Raising `intEn` again restarts the full T+1 cycle phase.
- R5: The terminal value is the concatenation of the high word (loaded with `termLoad` bit 1) above the low word (loaded with `termLoad` bit 0). A nonzero high word is honoured in the compare.
- R6: A rising edge on `extIn` with `extEn` high gives exactly one pulse, however long the input stays high. The pulse appears 3 cycles after the edge when `EXT_CDC`=1, or 1 cycle after it when `EXT_CDC`=0.
- R7: With `extEn` low, edges on `extIn` give no pulse. Raising `extEn` while `extIn` is already high gives no pulse.
- R8: Terminal word loads are ignored while `engineEn` is high and take effect while it is low.
- R9: All three sources may be enabled together. Events from different sources in the same cycle merge into one single-cycle pulse.
- R10: `syncOut` equals `syncPulse` in every cycle.
- R11: If the terminal value is lowered below the current count, the counter restarts with a pulse on the next compare, and does not run on toward wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| engineEn | input | 1 | Engine enabled; blocks terminal loads while high |
| intEn | input | 1 | Enable for the internal periodic source |
| extEn | input | 1 | Enable for the external input source |
| softEn | input | 1 | Enable for the software strobe source |
| softWrite | input | 1 | One-cycle strobe: a write of one to the software sync bit |
| termLoad | input | TERM_WORDS | Per-word load strobe for the terminal value (bit 0 low word) |
| termWord | input | WORD_W | Data for a terminal word load |
| extIn | input | 1 | External timing input, possibly asynchronous |
| syncPulse | output | 1 | Merged single-cycle sync pulse to the sequencer |
| syncOut | output | 1 | Sync output pin, a copy of the merged pulse |

## Verification
The bench targets the following corner cases:

- **Terminal lowered below the live count.** A design that compares with equality would then stall for about 2^64 cycles instead of restarting within two cycles.
- **Long high on the external input.** A level-sensitive design would pulse every cycle instead of once.
- **External source enabled while the input is already high.** A design that stops its edge history while the source is disabled would see a false edge.
- **Load attempted while the engine is enabled.** An unguarded design would change the period.
- **Software and external events landing on the same edge.** These must give one pulse.
- **High terminal word made nonzero.** A design that ignores the upper word would keep firing at the low-word period.

// File: rtl/tri_sync_pkg.sv
package tri_sync_pkg;

  // Strobes passed from the control module to the datapath each cycle.
  typedef struct packed {
    logic cntRun;      // internal counter may advance
    logic extFire;     // qualified external edge this cycle
    logic softFire;    // qualified software strobe this cycle
    logic termFreeze;  // terminal registers must hold
  } syncStrb_t;

endpackage

// File: rtl/tri_sync_ctrl.sv
module tri_sync_ctrl
  import tri_sync_pkg::*;
#(
  parameter int EXT_CDC    = 1,
  parameter int TERM_WORDS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  engineEn,
  input  logic                  intEn,
  input  logic                  extEn,
  input  logic                  softEn,
  input  logic                  softWrite,
  input  logic                  extIn,
  input  logic [TERM_WORDS-1:0] termLoad,
  output syncStrb_t             strb,
  output logic [TERM_WORDS-1:0] termWe
);

  logic extSeen;
  logic extPrev;
  logic extRise;

  // Optional two-stage synchronizer in front of the edge detector.
  generate
    if (EXT_CDC != 0) begin : g_cdc
      logic [1:0] metaQ;
      always_ff @(posedge clk) begin
        if (!rstN) metaQ <= '0;
        else       metaQ <= {metaQ[0], extIn};
      end
      assign extSeen = metaQ[1];
    end else begin : g_direct
      assign extSeen = extIn;
    end
  endgenerate

  // The edge history tracks the input even while the source is disabled,
  // so enabling during a high level does not look like an edge.
  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extSeen;
  end

  assign extRise = extSeen & ~extPrev;

  always_comb begin
    strb            = '0;
    strb.cntRun     = intEn;
    strb.extFire    = extEn & extRise;
    strb.softFire   = softEn & softWrite;
    strb.termFreeze = engineEn;
    termWe          = engineEn ? '0 : termLoad;
  end

  // R6
  ext_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.extFire |=> !strb.extFire);

endmodule

// File: rtl/tri_sync_dp.sv
module tri_sync_dp
  import tri_sync_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int TERM_WORDS = 2,
  parameter logic [WORD_W*TERM_WORDS-1:0] TERM_INIT = 999
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  syncStrb_t             strb,
  input  logic [TERM_WORDS-1:0] termWe,
  input  logic [WORD_W-1:0]     termWord,
  output logic                  syncPulse
);

  localparam int CNT_W = WORD_W * TERM_WORDS;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [TERM_WORDS-1:0][WORD_W-1:0] termReg;
  logic [CNT_W-1:0]                  termFlat;
  logic [CNT_W-1:0]                  cnt;
  logic                              intHit;

  // One load-enabled register per terminal word.
  generate
    for (genvar w = 0; w < TERM_WORDS; w++) begin : g_term
      always_ff @(posedge clk) begin
        if (!rstN)          termReg[w] <= TERM_INIT[w*WORD_W +: WORD_W];
        else if (termWe[w]) termReg[w] <= termWord;
      end
    end
  endgenerate

  assign termFlat = termReg;

  // Magnitude compare so a terminal lowered under the count still restarts.
  assign intHit = strb.cntRun && (cnt >= termFlat);

  always_ff @(posedge clk) begin
    if (!rstN)                      cnt <= '0;
    else if (!strb.cntRun || intHit) cnt <= '0;
    else                            cnt <= cnt + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncPulse <= 1'b0;
    else       syncPulse <= intHit | strb.extFire | strb.softFire;
  end

  // R4
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntRun |=> (cnt == '0));

  // R8
  term_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.termFreeze |=> $stable(termFlat));

  // R2
  soft_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.softFire |=> syncPulse);

  // R9
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |-> $past(intHit || strb.extFire || strb.softFire));

endmodule

// File: rtl/tri_sync_gen.sv
module tri_sync_gen
  import tri_sync_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int TERM_WORDS = 2,
  parameter int EXT_CDC    = 1,
  parameter logic [WORD_W*TERM_WORDS-1:0] TERM_INIT = 999
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  engineEn,
  input  logic                  intEn,
  input  logic                  extEn,
  input  logic                  softEn,
  input  logic                  softWrite,
  input  logic [TERM_WORDS-1:0] termLoad,
  input  logic [WORD_W-1:0]     termWord,
  input  logic                  extIn,
  output logic                  syncPulse,
  output logic                  syncOut
);

  syncStrb_t             strb;
  logic [TERM_WORDS-1:0] termWe;

  tri_sync_ctrl #(
    .EXT_CDC    (EXT_CDC),
    .TERM_WORDS (TERM_WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .engineEn  (engineEn),
    .intEn     (intEn),
    .extEn     (extEn),
    .softEn    (softEn),
    .softWrite (softWrite),
    .extIn     (extIn),
    .termLoad  (termLoad),
    .strb      (strb),
    .termWe    (termWe)
  );

  tri_sync_dp #(
    .WORD_W     (WORD_W),
    .TERM_WORDS (TERM_WORDS),
    .TERM_INIT  (TERM_INIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .termWe    (termWe),
    .termWord  (termWord),
    .syncPulse (syncPulse)
  );

  assign syncOut = syncPulse;

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !syncPulse);

endmodule

// File: tb/tri_sync_gen_bench.sv
module tri_sync_gen_bench;

  localparam int EXT_CDC = 1;
  localparam int EXT_LAT = (EXT_CDC != 0) ? 3 : 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        engineEn = 1'b0;
  logic        intEn = 1'b0;
  logic        extEn = 1'b0;
  logic        softEn = 1'b0;
  logic        softWrite = 1'b0;
  logic [1:0]  termLoad = '0;
  logic [31:0] termWord = '0;
  logic        extIn = 1'b0;
  logic        syncPulse;
  logic        syncOut;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  tri_sync_gen #(.EXT_CDC(EXT_CDC)) u_tri_sync_gen (
    .clk(clk), .rstN(rstN), .engineEn(engineEn), .intEn(intEn),
    .extEn(extEn), .softEn(softEn), .softWrite(softWrite),
    .termLoad(termLoad), .termWord(termWord), .extIn(extIn),
    .syncPulse(syncPulse), .syncOut(syncOut)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkPin(input string tag, input logic exp);
    chk({tag, " syncPulse"}, syncPulse, exp);
    chk({"R10 ", tag, " syncOut"}, syncOut, exp);
  endtask

  // Called right after a negedge; leaves right after a negedge.
  task automatic writeTerm(input int idx, input logic [31:0] v);
    termLoad[idx] = 1'b1;
    termWord = v;
    @(negedge clk);
    termLoad = '0;
  endtask

  task automatic toPulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!syncPulse && n < 300);
  endtask

  task automatic countPulses(input int cycles, output int p);
    p = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (syncPulse) p++;
    end
  endtask

  task automatic testReset();
    softEn = 1'b1;
    softWrite = 1'b1;
    repeat (3) @(negedge clk);
    chkPin("R1 in reset", 1'b0);
    softWrite = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chkPin("R1 after release", 1'b0);
    softEn = 1'b0;
  endtask

  task automatic testSoft();
    softEn = 1'b1;
    softWrite = 1'b1;
    @(negedge clk);
    softWrite = 1'b0;
    chkPin("R2 soft pulse", 1'b1);
    @(negedge clk);
    chkPin("R2 soft single cycle", 1'b0);
    softEn = 1'b0;
    softWrite = 1'b1;
    @(negedge clk);
    softWrite = 1'b0;
    chkPin("R2 soft disabled", 1'b0);
    @(negedge clk);
    chkPin("R2 soft disabled later", 1'b0);
  endtask

  task automatic testInternal();
    int n;
    writeTerm(0, 32'd5);
    intEn = 1'b1;
    toPulse(n);
    chk("R3 first internal pulse", n, 6);
    toPulse(n);
    chk("R3 internal period", n, 6);
    intEn = 1'b0;
    countPulses(20, n);
    chk("R4 idle no pulses", n, 0);
    intEn = 1'b1;
    repeat (3) @(negedge clk);
    intEn = 1'b0;
    repeat (2) @(negedge clk);
    intEn = 1'b1;
    toPulse(n);
    chk("R4 phase restart", n, 6);
    intEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testHighWord();
    int n;
    writeTerm(0, 32'd2);
    writeTerm(1, 32'd1);
    intEn = 1'b1;
    countPulses(40, n);
    chk("R5 high word blocks pulse", n, 0);
    intEn = 1'b0;
    @(negedge clk);
    writeTerm(1, 32'd0);
    intEn = 1'b1;
    toPulse(n);
    chk("R5 high word cleared period", n, 3);
    intEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testLock();
    int n;
    writeTerm(0, 32'd5);
    engineEn = 1'b1;
    writeTerm(0, 32'd1);
    intEn = 1'b1;
    toPulse(n);
    chk("R8 locked load ignored", n, 6);
    toPulse(n);
    chk("R8 locked period kept", n, 6);
    intEn = 1'b0;
    engineEn = 1'b0;
    @(negedge clk);
    writeTerm(0, 32'd2);
    intEn = 1'b1;
    toPulse(n);
    chk("R8 unlocked load taken", n, 3);
    intEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testLower();
    int n;
    writeTerm(0, 32'd20);
    intEn = 1'b1;
    repeat (10) @(negedge clk);
    writeTerm(0, 32'd3);
    n = 1;
    while (!syncPulse && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk("R11 restart after lowering", n, 2);
    toPulse(n);
    chk("R11 new period", n, 4);
    intEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testExt();
    int n;
    extEn = 1'b1;
    extIn = 1'b1;
    for (int i = 1; i <= EXT_LAT; i++) begin
      @(negedge clk);
      if (i < EXT_LAT) chkPin("R6 before latency", 1'b0);
    end
    chkPin("R6 ext pulse at latency", 1'b1);
    countPulses(30, n);
    chk("R6 long high single pulse", n, 0);
    extIn = 1'b0;
    countPulses(6, n);
    chk("R6 falling edge no pulse", n, 0);
    extEn = 1'b0;
    extIn = 1'b1;
    countPulses(6, n);
    chk("R7 disabled edge ignored", n, 0);
    extEn = 1'b1;
    countPulses(8, n);
    chk("R7 enable during high", n, 0);
    extIn = 1'b0;
    countPulses(5, n);
    extIn = 1'b1;
    countPulses(8, n);
    chk("R6 second edge one pulse", n, 1);
    extIn = 1'b0;
    extEn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic testMerge();
    int n;
    writeTerm(0, 32'd150);
    intEn = 1'b1;
    extEn = 1'b1;
    softEn = 1'b1;
    extIn = 1'b1;
    repeat (EXT_LAT - 1) @(negedge clk);
    softWrite = 1'b1;
    @(negedge clk);
    softWrite = 1'b0;
    chkPin("R9 coincident pulse", 1'b1);
    countPulses(20, n);
    chk("R9 merged single pulse", n, 0);
    intEn = 1'b0;
    extEn = 1'b0;
    softEn = 1'b0;
    extIn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSoft();
    testInternal();
    testHighWord();
    testLock();
    testLower();
    testExt();
    testMerge();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule